// File: doc/BRIEF.md
# Scaled Linear/Circular Address Generator

This block forms the effective address of a load or store. It adds a 32-bit base value to an offset. The offset is first scaled by the access size: byte, halfword, word or doubleword. The sum is either taken as is (linear) or confined to a power-of-two circular buffer that sits inside the base address (modulo). The result is registered and appears one clock after the request, together with a flag that says whether modulo arithmetic was applied.

The base register is named by a 5-bit selector. Bit 4 picks the bank (0 = bank A, 1 = bank B) and bits 3:0 give the register number inside the bank. Only registers 4 to 7 of either bank can use circular mode. Each of those eight registers has its own 2-bit field in a 32-bit mode-control word. Two 5-bit block-size fields in the same word set the buffer sizes. The register file, the memory port and the write-back of the updated base are outside this block.

Top module: `agu_modaddr`

## Requirements
- R1: While `rst_n` is low and on the first clock after it rises, `addr_valid`, `addr` and `circ_used` are 0.
- R2: `addr_valid` equals `req_valid` delayed by one clock. `addr` and `circ_used` load only on a clock where `req_valid` is 1 and hold their values otherwise.
- R3: The offset is shifted left by `acc_size` before the add: 0 = byte (no shift), 1 = halfword (1), 2 = word (2), 3 = doubleword (3).
- R4: In linear mode `addr` = `base_val` + scaled offset, modulo 2^32. The offset is two's complement, and a mode field of 00 selects linear.
- R5: A register whose number (`base_sel[3:0]`) is outside 4..7 always uses linear arithmetic, whatever `mode_ctl` holds.
- R6: The mode field of eligible register k (k = 4..7) of bank A is `mode_ctl[2(k-4)+1 : 2(k-4)]`. For bank B it is `mode_ctl[2(k-4)+9 : 2(k-4)+8]`. A field affects only its own register.
- R7: Field 01 selects circular mode with block size N0 = `mode_ctl[20:16]`. Field 10 selects circular mode with N1 = `mode_ctl[25:21]`. The buffer is 2^(N+1) bytes.
- R8: In circular mode the address bits at and above position N+1 are copied from `base_val`. The bits below are (base + scaled offset) modulo 2^(N+1), so negative offsets wrap to the top of the buffer. With N = 31 the result equals the linear sum.
- R9: Field 11 is reserved and gives linear arithmetic.
- R10: `circ_used` is 1 exactly when the registered address was produced in circular mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| base_sel | input | 5 | Base register selector: bit 4 bank, bits 3:0 number |
| base_val | input | 32 | Base register contents |
| ofs_val | input | 32 | Unscaled two's-complement offset |
| acc_size | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 double) |
| mode_ctl | input | 32 | Addressing-mode control word |
| addr_valid | output | 1 | Registered address valid |
| addr | output | 32 | Registered effective address |
| circ_used | output | 1 | Address produced in circular mode |

## Verification
The four size codes are applied with a small offset so that each shift amount gives a distinct sum. Negative offsets are used in both modes. In linear mode they separate a correct 32-bit wrap from a wrong one. In circular mode they separate a wrap to the top of the buffer from a borrow into the upper bits.

Eligible and ineligible registers in both banks are run against control words with all fields set, and with a single field set on the opposite bank. This exposes a wrong field index or a missing eligibility check. Modes 01, 10 and 11, small block sizes and N = 31 separate the two block-size sources, the reserved code and the full-width mask. Random traffic with idle gaps checks the hold behaviour against the model on every clock.

// File: rtl/agu_modaddr.sv
module agu_modaddr #(
  parameter int AW      = 32,
  parameter int NW      = 5,
  parameter int BS0_LSB = 16,
  parameter int BS1_LSB = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [4:0]    base_sel,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] ofs_val,
  input  logic [1:0]    acc_size,
  input  logic [31:0]   mode_ctl,
  output logic          addr_valid,
  output logic [AW-1:0] addr,
  output logic          circ_used
);
  localparam logic [NW-1:0] TOP = NW'(AW-1);

  logic          elig;
  logic [2:0]    fidx;
  logic [1:0]    fld;
  logic          use_circ;
  logic [NW-1:0] nsz;
  logic [AW-1:0] sofs, sum, mask, nxt;

  assign elig     = (base_sel[3:2] == 2'b01);
  assign fidx     = {base_sel[4], base_sel[1:0]};
  assign fld      = mode_ctl[{fidx, 1'b0} +: 2];
  assign use_circ = elig && (fld == 2'b01 || fld == 2'b10);
  assign nsz      = fld[1] ? mode_ctl[BS1_LSB +: NW] : mode_ctl[BS0_LSB +: NW];
  assign sofs     = ofs_val << acc_size;
  assign sum      = base_val + sofs;
  assign mask     = {AW{1'b1}} >> (TOP - nsz);
  assign nxt      = use_circ ? ((base_val & ~mask) | (sum & mask)) : sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      addr       <= '0;
      circ_used  <= 1'b0;
    end else begin
      addr_valid <= req_valid;
      if (req_valid) begin
        addr      <= nxt;
        circ_used <= use_circ;
      end
    end
  end
endmodule

// File: rtl/agu_modaddr_chk.sv
module agu_modaddr_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [4:0]    base_sel,
  input logic [AW-1:0] base_val,
  input logic [AW-1:0] ofs_val,
  input logic [1:0]    acc_size,
  input logic [31:0]   mode_ctl,
  input logic          addr_valid,
  input logic [AW-1:0] addr,
  input logic          circ_used
);
  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> addr_valid);
  // R2
  valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !addr_valid);
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(addr) && $stable(circ_used)));
  // R5
  inelig_linear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && base_sel[3:2] != 2'b01) |=> !circ_used);
  // R4
  all_linear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_ctl[15:0] == 16'h0) |=> !circ_used);
  // R3
  linear_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && base_sel[3:2] != 2'b01) |=>
      (addr == $past(base_val) + ($past(ofs_val) << $past(acc_size))));
endmodule

bind agu_modaddr agu_modaddr_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_sel(base_sel),
  .base_val(base_val), .ofs_val(ofs_val), .acc_size(acc_size),
  .mode_ctl(mode_ctl), .addr_valid(addr_valid), .addr(addr),
  .circ_used(circ_used)
);

// File: tb/tb_agu_modaddr.sv
`timescale 1ns/1ps
module tb_agu_modaddr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [4:0]  base_sel = '0;
  logic [31:0] base_val = '0;
  logic [31:0] ofs_val = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] mode_ctl = '0;
  logic        addr_valid;
  logic [31:0] addr;
  logic        circ_used;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  string etag = "R1";
  logic        e_v = 1'b0, e_c = 1'b0;
  logic [31:0] e_a = '0;
  bit          live = 1'b0;

  always #2 clk = ~clk;

  agu_modaddr dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_sel(base_sel),
    .base_val(base_val), .ofs_val(ofs_val), .acc_size(acc_size),
    .mode_ctl(mode_ctl), .addr_valid(addr_valid), .addr(addr),
    .circ_used(circ_used)
  );

  function automatic logic [31:0] model(input logic [4:0] sel, input logic [31:0] b,
                                        input logic [31:0] o, input logic [1:0] sz,
                                        input logic [31:0] ctl, output bit circ);
    int regno = int'(sel[3:0]);
    int bank  = int'(sel[4]);
    logic [31:0] so = o * (32'd1 << sz);
    int n = 0;
    circ = 0;
    if (regno >= 4 && regno <= 7) begin
      int idx = bank * 4 + regno - 4;
      int f = int'((ctl >> (2 * idx)) & 32'd3);
      if (f == 1) begin circ = 1; n = int'(ctl[20:16]); end
      if (f == 2) begin circ = 1; n = int'(ctl[25:21]); end
    end
    if (circ) begin
      longint unsigned blk  = 64'd1 << (n + 1);
      longint unsigned lowb = longint'(b) % blk;
      longint unsigned s    = (lowb + longint'(so)) % blk;
      return 32'(longint'(b) - lowb + s);
    end
    return b + so;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      e_v <= 1'b0; e_a <= '0; e_c <= 1'b0;
    end else begin
      e_v <= req_valid;
      etag <= req_valid ? tag : "R2";
      if (req_valid) begin
        bit c;
        e_a <= model(base_sel, base_val, ofs_val, acc_size, mode_ctl, c);
        e_c <= c;
      end
    end
  end

  always @(negedge clk) begin
    if (live && rst_n) begin
      checks++;
      if (addr_valid !== e_v || addr !== e_a || circ_used !== e_c) begin
        errors++;
        $display("FAIL %s: got v=%0b a=%08h c=%0b expected v=%0b a=%08h c=%0b",
                 etag, addr_valid, addr, circ_used, e_v, e_a, e_c);
      end
    end
  end

  task automatic req(input string t, input logic [4:0] sel, input logic [31:0] b,
                     input logic [31:0] o, input logic [1:0] sz, input logic [31:0] ctl);
    @(negedge clk);
    tag = t; req_valid = 1'b1; base_sel = sel; base_val = b;
    ofs_val = o; acc_size = sz; mode_ctl = ctl;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      base_val = $urandom; ofs_val = $urandom; mode_ctl = $urandom;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++; // R1 during reset
    if (addr_valid !== 1'b0 || addr !== '0 || circ_used !== 1'b0) begin
      errors++;
      $display("FAIL R1: got v=%0b a=%08h c=%0b expected 0 0 0", addr_valid, addr, circ_used);
    end
    rst_n = 1'b1;
    live = 1'b1;
    idle(1);
    // R3 each size code
    for (int s = 0; s < 4; s++) req("R3", 5'd0, 32'h0000_1000, 32'd5, 2'(s), 32'h0);
    // R4 negative offset wraps below zero
    req("R4", 5'd1, 32'h0000_0010, 32'hFFFF_FFF8, 2'd2, 32'h0);
    // R6 R7 A4 mode 01 with N0=3 (16 bytes)
    req("R7", 5'd4, 32'h1000_0008, 32'd3, 2'd2, (32'd3 << 16) | 32'h1);
    // R6 B7 mode 10 with N1=7 (256 bytes)
    req("R6", 5'h17, 32'h2345_67F0, 32'd5, 2'd2, (32'd7 << 21) | (32'd2 << 14));
    // R8 negative circular offset wraps to buffer top
    req("R8", 5'd4, 32'h2000_0002, 32'hFFFF_FFFF, 2'd3, (32'd3 << 16) | 32'h1);
    // R8 N=31 equals linear
    req("R8", 5'd5, 32'hFFFF_FFF0, 32'd8, 2'd2, (32'd31 << 16) | (32'h1 << 2));
    // R5 ineligible registers with every field set
    req("R5", 5'd2, 32'h3000_000C, 32'd4, 2'd2, 32'h0062_5555);
    req("R5", 5'd8, 32'h3000_000C, 32'd4, 2'd2, 32'h0062_5555);
    req("R5", 5'h1C, 32'h3000_000C, 32'd4, 2'd2, 32'h0062_AAAA);
    // R6 field set for A5 only, request on B5
    req("R6", 5'h15, 32'h4000_000E, 32'd4, 2'd0, (32'd2 << 16) | (32'h1 << 2));
    // R9 reserved code
    req("R9", 5'd6, 32'h5000_000E, 32'd4, 2'd0, (32'd2 << 16) | (32'h3 << 4));
    // R10 flag falls after circular request
    req("R10", 5'd7, 32'h6000_0000, 32'd9, 2'd0, (32'd2 << 16) | (32'h1 << 6));
    req("R10", 5'd7, 32'h6000_0000, 32'd9, 2'd0, 32'h0);
    // R2 hold with idle gaps
    req("R2", 5'd4, 32'h7000_0004, 32'd1, 2'd1, (32'd4 << 16) | 32'h1);
    idle(4);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ctl = {6'd0, 5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)), 16'($urandom)};
      req("R8", 5'($urandom), $urandom, $urandom_range(0, 1) ? $urandom : 32'($urandom_range(0, 40)) - 32'd20,
          2'($urandom), ctl);
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule